// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

A 16-bit timer/counter that advances on qualified ticks of a clock-enable input, which stands for whichever clock source the surrounding clock system selected. A power-of-two prescaler sits between that enable and the count. Four operating modes are selected by a 2-bit field: halted, counting up to a period value and wrapping, free-running over the full 16-bit range, and a symmetric swing that climbs to the period value and descends back to zero.

Software can clear the timer, which returns the count, the prescaler phase and the slope to their initial state. It can also load the count directly. The block drives the count, the current slope and two single-cycle event pulses. One pulse marks arrival at the period value. The other marks arrival at zero, which in free-running mode is the wrap from 0xFFFF. These pulses feed the compare and interrupt logic around the block. In the two period-based modes, a period value of zero parks the timer. Any nonzero period lets it resume from where it stopped.

Top module: `multimode_timer`

## Requirements
- R1: While reset is applied and after it, until the first advance, `count` is 0, `dir_down` is 0, and both `hit_pulse` and `zero_pulse` are 0.
- R2: With `mode_sel` = 2'b00 (halted), `count` and `dir_down` keep their values and the prescaler phase does not move, whatever `tick_en` does.
- R3: With `mode_sel` = 2'b01 (up), each advance adds 1 to `count`. An advance from a count equal to or above `period` loads 0 instead, so one cycle takes `period`+1 advances.
- R4: With `mode_sel` = 2'b10 (free-running), each advance adds 1 to `count`, and 0xFFFF is followed by 0.
- R5: With `mode_sel` = 2'b11 (swing), the count climbs by 1 until it reaches `period`, then falls by 1 until it reaches 0, then climbs again. `dir_down` is 1 after every falling step and 0 after every rising step.
- R6: `div_sel` = n lets one advance happen every 2^n-th cycle in which `tick_en` is 1 (n = 0..3 gives divide by 1, 2, 4, 8). Cycles with `tick_en` at 0 do not count.
- R7: `hit_pulse` is 1 for exactly the one cycle after an advance that brought `count` to `period`, in up or swing mode only.
- R8: `zero_pulse` is 1 for exactly the one cycle after an advance that brought `count` to 0, in any mode. This covers the 0xFFFF-to-0 wrap in free-running mode and the bottom of the falling slope in swing mode.
- R9: In up or swing mode, a `period` of 0 freezes `count`, `dir_down` and the prescaler phase. A later nonzero `period` resumes counting from the frozen count.
- R10: A `clr` strobe sets `count` to 0, the prescaler phase to 0 and `dir_down` to 0 on the next edge, with no pulse. It takes priority over a load and over an advance.
- R11: A `cnt_load` sets `count` to `cnt_wdata` on the next edge. That edge raises no pulse and makes no advance, and the prescaler keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock-enable from the selected clock source |
| mode_sel | input | 2 | 00 halted, 01 up, 10 free-running, 11 swing |
| div_sel | input | 2 | Prescale select, divide by 2^div_sel |
| clr | input | 1 | Clear strobe for count, prescaler and slope |
| period | input | 16 | Period value for up and swing modes |
| cnt_load | input | 1 | Software load strobe for the count |
| cnt_wdata | input | 16 | Value loaded into the count |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while the count is on a falling slope |
| hit_pulse | output | 1 | One-cycle pulse on arrival at the period value |
| zero_pulse | output | 1 | One-cycle pulse on arrival at zero |

## Verification
Every result of this block is due one edge after its cause. A qualifying tick moves `count` and `dir_down` at that same edge, and the event pulses are registered alongside the count, so they appear in the same cycle as the value they announce. A clear or a load likewise shows at the next edge. The bench drives inputs on the falling edge and samples on the following falling edge, half a period after the rising edge that acts on them. A behavioural model updated at each rising edge is compared with all four outputs at every falling edge. Directed sequences count the exact number of edges from a clear to each expected value, such as the eighth tick under divide-by-8 or the third step of a swing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_HALT  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_FREE  = 2'b10,
    MODE_SWING = 2'b11
  } tmr_mode_e;

  function automatic logic uses_period(tmr_mode_e m);
    return (m == MODE_UP) || (m == MODE_SWING);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] div_sel,
  output logic             adv
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] phase_q, phase_d, term;
  logic          at_term;

  always_comb begin
    for (int i = 0; i < PW; i++) term[i] = (i < int'(div_sel));
  end

  assign at_term = (phase_q >= term);

  always_comb begin
    phase_d = phase_q;
    if (clr)                 phase_d = '0;
    else if (run && tick_en) phase_d = at_term ? '0 : phase_q + PW'(1);
  end

  assign adv = run && tick_en && !clr && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  tmr_mode_e      mode,
  input  logic [W-1:0]   cur,
  input  logic           cur_down,
  input  logic [W-1:0]   period,
  output logic [W-1:0]   nxt,
  output logic           nxt_down
);
  always_comb begin
    nxt      = cur;
    nxt_down = cur_down;
    unique case (mode)
      MODE_UP: begin
        nxt      = (cur >= period) ? '0 : cur + W'(1);
        nxt_down = 1'b0;
      end
      MODE_FREE: begin
        nxt      = cur + W'(1);
        nxt_down = 1'b0;
      end
      MODE_SWING: begin
        if (!cur_down) begin
          if (cur >= period) begin
            nxt      = cur - W'(1);
            nxt_down = 1'b1;
          end else begin
            nxt      = cur + W'(1);
            nxt_down = 1'b0;
          end
        end else begin
          if (cur == '0) begin
            nxt      = W'(1);
            nxt_down = 1'b0;
          end else begin
            nxt      = cur - W'(1);
            nxt_down = 1'b1;
          end
        end
      end
      default: begin
        nxt      = cur;
        nxt_down = cur_down;
      end
    endcase
  end
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import tmr_pkg::*;
#(
  parameter int W     = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       mode_sel,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             clr,
  input  logic [W-1:0]     period,
  input  logic             cnt_load,
  input  logic [W-1:0]     cnt_wdata,
  output logic [W-1:0]     count,
  output logic             dir_down,
  output logic             hit_pulse,
  output logic             zero_pulse
);
  logic [1:0]   rst_sync;
  logic         rst_s_n;
  tmr_mode_e    mode;
  logic         run, adv;
  logic [W-1:0] cnt_q, cnt_d, step_cnt;
  logic         down_q, down_d, step_down;
  logic         hit_q, hit_d, zero_q, zero_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign mode = tmr_mode_e'(mode_sel);
  assign run  = (mode != MODE_HALT) && !(uses_period(mode) && (period == '0));

  tmr_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (run),
    .tick_en (tick_en),
    .clr     (clr),
    .div_sel (div_sel),
    .adv     (adv)
  );

  tmr_step #(.W(W)) u_step (
    .mode     (mode),
    .cur      (cnt_q),
    .cur_down (down_q),
    .period   (period),
    .nxt      (step_cnt),
    .nxt_down (step_down)
  );

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    hit_d  = 1'b0;
    zero_d = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (cnt_load) begin
      cnt_d  = cnt_wdata;
    end else if (adv) begin
      cnt_d  = step_cnt;
      down_d = step_down;
      hit_d  = uses_period(mode) && (step_cnt == period);
      zero_d = (step_cnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      hit_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      hit_q  <= hit_d;
      zero_q <= zero_d;
    end
  end

  assign count      = cnt_q;
  assign dir_down   = down_q;
  assign hit_pulse  = hit_q;
  assign zero_pulse = zero_q;
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_ok,
  input logic [1:0]   mode_sel,
  input logic         clr,
  input logic [W-1:0] period,
  input logic         cnt_load,
  input logic [W-1:0] cnt_wdata,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         hit_pulse,
  input logic         zero_pulse
);
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_sel == 2'b00 && !clr && !cnt_load) |=> ($stable(count) && $stable(dir_down)));

  a_r7_hit_at_period: assert property (@(posedge clk) disable iff (!rst_ok)
    hit_pulse |-> (count == $past(period)));

  a_r8_zero_at_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    zero_pulse |-> (count == '0));

  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({hit_pulse, zero_pulse}));

  a_r9_zero_period_parks: assert property (@(posedge clk) disable iff (!rst_ok)
    ((mode_sel == 2'b01 || mode_sel == 2'b11) && period == '0 && !clr && !cnt_load)
      |=> $stable(count));

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    clr |=> (count == '0 && !dir_down && !hit_pulse && !zero_pulse));

  a_r11_load_value: assert property (@(posedge clk) disable iff (!rst_ok)
    (cnt_load && !clr) |=> (count == $past(cnt_wdata) && !hit_pulse && !zero_pulse));
endmodule

bind multimode_timer tmr_checks #(.W(W)) u_tmr_checks (
  .clk        (clk),
  .rst_ok     (rst_s_n),
  .mode_sel   (mode_sel),
  .clr        (clr),
  .period     (period),
  .cnt_load   (cnt_load),
  .cnt_wdata  (cnt_wdata),
  .count      (count),
  .dir_down   (dir_down),
  .hit_pulse  (hit_pulse),
  .zero_pulse (zero_pulse)
);

// File: tb/test_multimode_timer.sv
module test_multimode_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [1:0]  div_sel = 2'b00;
  logic        clr = 1'b0;
  logic [15:0] period = 16'd0;
  logic        cnt_load = 1'b0;
  logic [15:0] cnt_wdata = 16'd0;
  logic [15:0] count;
  logic        dir_down, hit_pulse, zero_pulse;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  int m_cnt = 0, m_pre = 0, m_down = 0, m_hit = 0, m_zero = 0;

  always #5 clk = ~clk;

  multimode_timer i_multimode_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .div_sel(div_sel), .clr(clr), .period(period), .cnt_load(cnt_load),
    .cnt_wdata(cnt_wdata), .count(count), .dir_down(dir_down),
    .hit_pulse(hit_pulse), .zero_pulse(zero_pulse)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference, one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_down = 0; m_hit = 0; m_zero = 0;
    end else if (clr) begin
      m_cnt = 0; m_pre = 0; m_down = 0; m_hit = 0; m_zero = 0;
    end else begin
      int  term;
      int  md;
      int  per;
      bit  run, adv, perm;
      md   = int'(mode_sel);
      per  = int'(period);
      perm = (md == 1) || (md == 3);
      run  = (md != 0) && !(perm && per == 0);
      term = (1 << div_sel) - 1;
      adv  = 1'b0;
      if (run && tick_en) begin
        if (m_pre >= term) begin m_pre = 0; adv = 1'b1; end
        else m_pre = m_pre + 1;
      end
      m_hit = 0; m_zero = 0;
      if (cnt_load) m_cnt = int'(cnt_wdata);
      else if (adv) begin
        if (md == 1) begin
          m_cnt = (m_cnt >= per) ? 0 : m_cnt + 1; m_down = 0;
        end else if (md == 2) begin
          m_cnt = (m_cnt + 1) % 65536; m_down = 0;
        end else begin
          if (m_down == 0) begin
            if (m_cnt >= per) begin m_cnt = m_cnt - 1; m_down = 1; end
            else m_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin m_cnt = 1; m_down = 0; end
            else m_cnt = m_cnt - 1;
          end
        end
        m_hit  = (perm && m_cnt == per) ? 1 : 0;
        m_zero = (m_cnt == 0) ? 1 : 0;
      end
    end
  end

  function automatic string mode_tag(input logic [1:0] m, input logic [15:0] p);
    if ((m == 2'b01 || m == 2'b11) && p == 16'd0) return "R9";
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(int'(count) == m_cnt, mode_tag(mode_sel, period), "count", int'(count), m_cnt);
      chk(int'(dir_down) == m_down, "R5", "dir_down", int'(dir_down), m_down);
      chk(int'(hit_pulse) == m_hit, "R7", "hit_pulse", int'(hit_pulse), m_hit);
      chk(int'(zero_pulse) == m_zero, "R8", "zero_pulse", int'(zero_pulse), m_zero);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear;
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk(count == 16'd0 && !dir_down && !hit_pulse && !zero_pulse, "R1", "reset outputs",
        int'({count, dir_down, hit_pulse, zero_pulse}), 0);
    rst_n = 1'b1;
    cyc(4);
    chk(count == 16'd0 && !dir_down, "R1", "after release", int'(count), 0);
    cmp_en = 1'b1;

    // R3: up mode, period 2, divide by 1
    tick_en = 1'b1; mode_sel = 2'b01; period = 16'd2; div_sel = 2'd0;
    do_clear();
    chk(count == 16'd0, "R10", "clear count", int'(count), 0);
    cyc(1); chk(count == 16'd1, "R3", "up step 1", int'(count), 1);
    cyc(1); chk(count == 16'd2 && hit_pulse, "R7", "up hit", int'(count), 2);
    cyc(1); chk(count == 16'd0 && zero_pulse, "R8", "up wrap", int'(count), 0);
    cyc(1); chk(count == 16'd1 && !zero_pulse, "R3", "up restart", int'(count), 1);
    cyc(20);

    // R11: load above period in up mode, then wrap
    cnt_load = 1'b1; cnt_wdata = 16'd9; cyc(1); cnt_load = 1'b0;
    chk(count == 16'd9 && !hit_pulse && !zero_pulse, "R11", "load", int'(count), 9);
    cyc(1); chk(count == 16'd0 && zero_pulse, "R3", "wrap from above", int'(count), 0);

    // R6: divide by 8 in free-running mode
    mode_sel = 2'b10; div_sel = 2'd3;
    do_clear();
    cyc(7); chk(count == 16'd0, "R6", "div8 before 8th tick", int'(count), 0);
    cyc(1); chk(count == 16'd1, "R6", "div8 8th tick", int'(count), 1);
    // R6: ticks gated by tick_en
    tick_en = 1'b0; cyc(20);
    chk(count == 16'd1, "R6", "no tick no advance", int'(count), 1);
    // irregular tick pattern under several divisors
    for (int i = 0; i < 120; i++) begin
      tick_en = ((i % 3) != 1);
      div_sel = 2'(i / 30);
      cyc(1);
    end
    tick_en = 1'b1; div_sel = 2'd0;

    // R4: wrap of free-running count
    cnt_load = 1'b1; cnt_wdata = 16'hFFFE; cyc(1); cnt_load = 1'b0;
    chk(count == 16'hFFFE, "R11", "load FFFE", int'(count), 16'hFFFE);
    cyc(1); chk(count == 16'hFFFF, "R4", "to FFFF", int'(count), 16'hFFFF);
    cyc(1); chk(count == 16'd0 && zero_pulse, "R4", "FFFF wraps to 0", int'(count), 0);

    // R5: swing, period 2
    mode_sel = 2'b11; period = 16'd2;
    do_clear();
    cyc(2); chk(count == 16'd2 && hit_pulse && !dir_down, "R5", "swing top", int'(count), 2);
    cyc(1); chk(count == 16'd1 && dir_down, "R5", "swing falling", int'(dir_down), 1);
    cyc(1); chk(count == 16'd0 && zero_pulse && dir_down, "R8", "swing bottom", int'(count), 0);
    cyc(1); chk(count == 16'd1 && !dir_down, "R5", "swing rising", int'(dir_down), 0);
    period = 16'd5; div_sel = 2'd1; cyc(40);

    // R10: clear during fall with load also requested
    period = 16'd3; div_sel = 2'd0;
    do_clear(); cyc(4);
    chk(dir_down == 1'b1, "R5", "falling before clear", int'(dir_down), 1);
    clr = 1'b1; cnt_load = 1'b1; cnt_wdata = 16'd77; cyc(1);
    clr = 1'b0; cnt_load = 1'b0;
    chk(count == 16'd0 && !dir_down && !zero_pulse, "R10", "clear beats load", int'(count), 0);

    // R9: zero period parks the timer
    cyc(2);
    period = 16'd0; cyc(1);
    begin
      logic [15:0] held;
      held = count;
      cyc(10);
      chk(count == held, "R9", "parked", int'(count), int'(held));
      period = 16'd6; cyc(1);
      chk(count != held, "R9", "resumed", int'(count), int'(held) + 1);
    end
    cyc(30);

    // R2: halted mode ignores ticks
    mode_sel = 2'b00;
    begin
      logic [15:0] held;
      cyc(1);
      held = count;
      cyc(15);
      chk(count == held, "R2", "halted", int'(count), int'(held));
    end
    mode_sel = 2'b01; period = 16'd4; div_sel = 2'd2; cyc(40);

    done = 1'b1;
    finish_run();
  end
endmodule